// File: doc/BRIEF.md
# Cross-Domain Clock Ratio Monitor

This block measures how fast a device clock runs compared with a reference clock. It reports the ratio of the two as an unsigned fixed-point number, with 16 integer bits and 16 fraction bits, in the reference domain. A fixed window of reference cycles sets the measurement period. At the end of each window the block publishes a new ratio and pulses a one-cycle strobe. A value of 0 means the measured clock has stopped. Software or health logic can compare the value with the rate it expects, for example a device clock that should run at one fortieth of the serial line rate.

The measured domain holds a free-running edge counter. At every window end the reference domain sends a toggle request across the boundary. The measured domain takes a snapshot of its counter and toggles an acknowledge back. Both toggles pass through two-flop synchronizers. The snapshot register holds still while the acknowledge travels, so the reference domain can read all of its bits safely. The difference between two snapshots that follow one another, shifted into place, gives the ratio.

If a request is still unanswered when the next window closes, the clock is taken as stopped and the block publishes 0. When the clock comes back, the late snapshot is thrown away, because it was taken at an arbitrary time. A new baseline must be taken before a non-zero value can appear again.

Top module: `clk_ratio_monitor`

## Requirements
- R1: Once the measured clock has run steadily, `ratio_o` equals f_meas/f_ref as unsigned 16.16 fixed point. Bits [31:16] hold the integer part and bits [15:0] the fraction. The value is the count of measured edges in one window multiplied by 2^(16-WIN_LOG2), accurate to within two edge counts.
- R2: `ratio_upd_o` pulses high for exactly one reference cycle at every window end, and the window end comes once every 2^WIN_LOG2 reference cycles.
- R3: `ratio_o` changes only in the cycle in which `ratio_upd_o` is high.
- R4: If a window closes while the snapshot request from the previous window end is still unanswered, that window's publication is exactly 0.
- R5: While reset is held and right after it is released, `ratio_o` is 0 and `ratio_upd_o` is low. The first two publications after reset are 0, because no baseline snapshot exists yet.
- R6: After a stopped clock starts again, every publication is either 0 or a correct ratio per R1. A snapshot taken late after a stop is never used as a baseline.
- R7: At most one snapshot request is outstanding at any time. An acknowledge is accepted only while a request is pending, and the measured-domain snapshot changes only when a new request is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; all outputs are synchronous to it |
| meas_clk_i | input | 1 | Clock whose frequency is measured |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| ratio_o | output | 32 | Unsigned 16.16 ratio f_meas/f_ref; 0 when the measured clock is stopped |
| ratio_upd_o | output | 1 | One-cycle strobe marking a new `ratio_o` value |

## Verification
The bench drives the measured clock at twice, half and 0.8 times the reference rate, and also at the same rate. Each published value is compared against the ideal fraction within a two-edge tolerance. A design that leaves out the window-size shift, or that takes the difference between the wrong snapshots, misses these values by large factors. The bench stops the measured clock in the middle of a run and demands exact zeros. A design that keeps a stale value, or waits forever for the acknowledge, fails this check. After the clock restarts, any value that is neither zero nor correct is reported. Such a value would come from a partial interval measured against a late snapshot. The bench also checks the spacing between strobes and that `ratio_o` holds steady in the middle of each window.

// File: rtl/crm_pkg.sv
package crm_pkg;
  localparam int unsigned INT_W  = 16;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned RES_W  = INT_W + FRAC_W;
  typedef logic [RES_W-1:0] ratio_t;
endpackage

// File: rtl/crm_sync.sv
module crm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/crm_window.sv
module crm_window #(
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic end_o
);
  logic [WIN_LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign end_o = &cnt_q;
endmodule

// File: rtl/crm_meas_snap.sv
module crm_meas_snap #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             meas_clk_i,
  input  logic             rst_ni,
  input  logic             req_i,   // toggle from reference domain
  output logic             ack_o,   // toggle back, raw flop
  output logic [CNT_W-1:0] snap_o
);
  logic             req_s;
  logic             ack_q;
  logic [CNT_W-1:0] edge_cnt_q;
  logic [CNT_W-1:0] snap_q;
  logic             new_req;

  crm_sync #(.STAGES(2)) u_req_sync (
    .clk_i (meas_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  assign new_req = req_s ^ ack_q;

  always_ff @(posedge meas_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt_q <= '0;
      snap_q     <= '0;
      ack_q      <= 1'b0;
    end else begin
      edge_cnt_q <= edge_cnt_q + 1'b1;
      if (new_req) begin
        snap_q <= edge_cnt_q;
        ack_q  <= req_s;
      end
    end
  end

  assign ack_o  = ack_q;
  assign snap_o = snap_q;

  AST_SNAP_HOLD: assert property (@(posedge meas_clk_i) disable iff (!rst_ni)
    !new_req |=> $stable(snap_q)); // R7
endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor
  import crm_pkg::*;
#(
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic         ref_clk_i,
  input  logic         meas_clk_i,
  input  logic         rst_ni,
  output logic [31:0]  ratio_o,
  output logic         ratio_upd_o
);
  localparam int unsigned CNT_W = WIN_LOG2 + INT_W;
  localparam int unsigned SHIFT = FRAC_W - WIN_LOG2;

  logic             win_end;
  logic             req_q;
  logic             ack_raw, ack_s, ack_seen_q;
  logic [CNT_W-1:0] snap;
  logic [CNT_W-1:0] prev_snap_q, delta_q;
  logic             prev_valid_q, delta_valid_q, stale_q;
  ratio_t           ratio_q;
  logic             upd_q;
  logic             pending, ack_edge, stopped;

  crm_window #(.WIN_LOG2(WIN_LOG2)) u_window (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .end_o (win_end)
  );

  crm_meas_snap #(.CNT_W(CNT_W)) u_meas (
    .meas_clk_i(meas_clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_q),
    .ack_o     (ack_raw),
    .snap_o    (snap)
  );

  crm_sync #(.STAGES(2)) u_ack_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_raw),
    .q_o   (ack_s)
  );

  assign pending  = req_q ^ ack_seen_q;
  assign ack_edge = ack_s ^ ack_seen_q;
  assign stopped  = pending && !ack_edge;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q         <= 1'b0;
      ack_seen_q    <= 1'b0;
      prev_snap_q   <= '0;
      delta_q       <= '0;
      prev_valid_q  <= 1'b0;
      delta_valid_q <= 1'b0;
      stale_q       <= 1'b0;
      ratio_q       <= '0;
      upd_q         <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      // snapshot is stable: it was written before the ack toggled
      if (ack_edge) begin
        ack_seen_q  <= ack_s;
        prev_snap_q <= snap;
        if (stale_q) begin
          stale_q <= 1'b0;   // late snapshot, not a baseline
        end else begin
          prev_valid_q <= 1'b1;
          if (prev_valid_q) begin
            delta_q       <= snap - prev_snap_q;
            delta_valid_q <= 1'b1;
          end
        end
      end
      if (win_end) begin
        upd_q <= 1'b1;
        if (stopped) begin
          ratio_q       <= '0;
          stale_q       <= 1'b1;
          prev_valid_q  <= 1'b0;
          delta_valid_q <= 1'b0;
        end else begin
          req_q   <= ~req_q;
          ratio_q <= delta_valid_q ? (ratio_t'(delta_q) << SHIFT) : '0;
        end
      end
    end
  end

  assign ratio_o     = ratio_q;
  assign ratio_upd_o = upd_q;

  AST_UPD_PULSE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ratio_upd_o |=> !ratio_upd_o); // R2
  AST_RATIO_HOLD: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !ratio_upd_o |-> $stable(ratio_o)); // R3
  AST_STOP_ZERO: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (win_end && stopped) |=> (ratio_upd_o && ratio_o == '0)); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ack_edge |-> pending); // R7
endmodule

// File: tb/clk_ratio_monitor_bench.sv
`timescale 1ns/1ps
module clk_ratio_monitor_bench;
  localparam int unsigned WIN_LOG2 = 8;
  localparam int unsigned WIN      = 1 << WIN_LOG2;
  localparam real         REF_PER  = 4.0;
  localparam int          TOL      = 2 << (16 - WIN_LOG2);

  typedef enum logic [1:0] {M_ZERO, M_NEAR, M_ZERO_OR_NEAR, M_SKIP} mode_e;
  typedef struct {
    mode_e mode;
    int    exp;
    string req;
  } item_t;

  logic        ref_clk = 1'b0;
  logic        meas_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ratio;
  logic        upd;

  real meas_half = 4.0;
  bit  meas_run  = 1'b1;

  int checks = 0;
  int fails  = 0;
  item_t q[$];
  logic [31:0] last_pub = '0;

  clk_ratio_monitor #(.WIN_LOG2(WIN_LOG2)) u_clk_ratio_monitor (
    .ref_clk_i  (ref_clk),
    .meas_clk_i (meas_clk),
    .rst_ni     (rst_n),
    .ratio_o    (ratio),
    .ratio_upd_o(upd)
  );

  always #(REF_PER/2) ref_clk = ~ref_clk;

  initial forever begin
    if (meas_run) #(meas_half) meas_clk = ~meas_clk;
    else          #1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input real per);
    return int'(REF_PER / per * 65536.0);
  endfunction

  function automatic bit near(input int act, input int exp);
    return (act >= exp - TOL) && (act <= exp + TOL);
  endfunction

  // monitor: strobe spacing and scoreboard compare
  int  since = 0;
  bit  seen_first = 1'b0;
  always @(negedge ref_clk) begin
    if (!rst_n) begin
      since = 0;
      seen_first = 1'b0;
    end else begin
      since++;
      if (upd) begin
        if (seen_first) check(since == WIN, "R2", since, WIN);
        seen_first = 1'b1;
        since = 0;
        last_pub = ratio;
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          case (it.mode)
            M_ZERO:         check(ratio == 0, it.req, int'(ratio), 0);
            M_NEAR:         check(near(int'(ratio), it.exp), it.req, int'(ratio), it.exp);
            M_ZERO_OR_NEAR: check(ratio == 0 || near(int'(ratio), it.exp), it.req, int'(ratio), it.exp);
            default: ;
          endcase
        end
      end
    end
  end

  // driver: queue one expectation, wait for it, then probe mid-window hold
  task automatic expect_pub(input mode_e m, input int exp, input string req);
    item_t it;
    it.mode = m;
    it.exp  = exp;
    it.req  = req;
    q.push_back(it);
    wait (q.size() == 0);
    repeat (WIN/2) @(negedge ref_clk);
    if (m != M_SKIP) check(ratio == last_pub, "R3", int'(ratio), int'(last_pub));
  endtask

  task automatic run_rate(input real per, input int settle, input int n, input string req);
    meas_half = per / 2.0;
    meas_run  = 1'b1;
    for (int i = 0; i < settle; i++) expect_pub(M_SKIP, 0, req);
    for (int i = 0; i < n; i++)      expect_pub(M_NEAR, ideal(per), req);
  endtask

  initial begin
    repeat (5) @(negedge ref_clk);
    check(ratio == 0, "R5", int'(ratio), 0);
    check(upd == 1'b0, "R5", int'(upd), 0);
    rst_n = 1'b1;
    @(negedge ref_clk);
    check(ratio == 0, "R5", int'(ratio), 0);
    check(upd == 1'b0, "R5", int'(upd), 0);

    // first two publications carry no baseline
    expect_pub(M_ZERO, 0, "R5");
    expect_pub(M_ZERO, 0, "R5");
    for (int i = 0; i < 3; i++) expect_pub(M_NEAR, ideal(8.0), "R1");

    run_rate(2.0, 3, 3, "R1");
    run_rate(5.0, 3, 3, "R1");

    // stop measured clock
    meas_run = 1'b0;
    expect_pub(M_SKIP, 0, "R4");
    for (int i = 0; i < 3; i++) expect_pub(M_ZERO, 0, "R4");

    // resume at equal rate: only 0 or correct values allowed
    meas_half = 2.0;
    meas_run  = 1'b1;
    for (int i = 0; i < 4; i++) expect_pub(M_ZERO_OR_NEAR, ideal(4.0), "R6");
    for (int i = 0; i < 2; i++) expect_pub(M_NEAR, ideal(4.0), "R6");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(REF_PER * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule